// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of a dual-slope integrating analog-to-digital converter. It steps the analog front end through four phases: offset nulling (auto-zero), integration of the input for a fixed time, integration back toward zero against the reference (de-integrate), and a short discharge of the integrator (zero-integrator). It drives a one-hot set of phase selects for the analog switches. It samples a comparator that reports the sign of the integrator output, and counts the de-integrate clocks into a 5-digit BCD reading.

Each conversion occupies a fixed number of clocks. The integration time is fixed, and de-integrate and discharge vary in length, so auto-zero takes up whatever clocks remain. This keeps the conversion rate constant. A run/hold input lets the converter free-run, or finish its current conversion and wait for a trigger. When a conversion ends, the block registers the reading, an overrange flag, an underrange flag and the input polarity, and holds them until the next conversion updates them.

Top module: `dsc_sequencer`

## Requirements
- R1: Exactly one bit of `phase_sel_o` is high at any time: bit 0 auto-zero, bit 1 integrate, bit 2 de-integrate, bit 3 zero-integrator. Phases advance only in the order 0, 1, 2, 3, 0.
- R2: While `run_i` stays high, successive conversions start exactly CYCLE_CLKS clocks apart.
- R3: The integrate phase lasts exactly INT_COUNTS+1 clocks.
- R4: The reading is the index k of the first de-integrate clock (the first clock is index 0) at which `comp_i` differs from the sampled polarity. The first de-integrate clock adds no count. `reading_o` holds BCD, with decimal digit i in bits 4i+3 down to 4i, least significant digit at bit 0.
- R5: `pol_o` takes the value of `comp_i` on the last integrate clock. It changes only on entry to de-integrate, and it stays valid for a reading of zero.
- R6: `busy_o` is high exactly during integrate and de-integrate. De-integrate ends on the clock after the crossing is sampled, or when the count would pass FULL_SCALE.
- R7: If no crossing arrives, de-integrate ends with a count of FULL_SCALE+1, which becomes the reading. `over_o` then rises, and it falls on entry to the next de-integrate.
- R8: `under_o` rises when a reading of UNDER_LIMIT or less is registered, and falls on entry to the next integrate.
- R9: Zero-integrator lasts ZI_NORM clocks, or ZI_OVER clocks after an overrange conversion.
- R10: `reading_o`, `over_o` and `under_o` take their new values at the end of the first zero-integrator clock, which is the clock after `busy_o` falls.
- R11: `run_i` is sampled only on the last clock of a conversion. If it is low there, auto-zero continues and the result is held. A later clock with `run_i` high starts integrate on the next clock.
- R12: A high pulse on `run_i` that ends before the last clock of the conversion starts no new conversion.
- R13: Under reset the block is in auto-zero with `busy_o`, `pol_o`, `over_o`, `under_o` low and `reading_o` zero. Reset is released through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| comp_i | input | 1 | Comparator: high when the integrator output is positive |
| run_i | input | 1 | High to free-run, low to hold after the current conversion |
| phase_sel_o | output | 4 | One-hot analog switch selects (auto-zero, integrate, de-integrate, zero-integrator) |
| busy_o | output | 1 | High during integrate and de-integrate |
| pol_o | output | 1 | Sign of the last input, high for positive |
| over_o | output | 1 | Last reading exceeded full scale |
| under_o | output | 1 | Last reading at or below the underrange limit |
| reading_o | output | 4*DIGITS | Registered BCD reading |

## Verification
The assertions watch the phase selects on every cycle. They check that exactly one select is high and that phases move only forward, and they count the integrate length. They also check that polarity changes only on entry to de-integrate, that each flag is clear on entry to the phase that clears it, and that the reading changes only after the first zero-integrator clock. Other behaviour depends on the analog stimulus and on the run input, so only the bench's scenarios can show it. This covers the exact count for crossings at index 0, at the underrange limit and at full scale, and the cut-off one count past full scale. It also covers the longer discharge after an overrange, the fixed spacing between conversions, and the hold and trigger behaviour, including an early pulse that is ignored.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  // One-hot phase encoding; bit order is what the analog switches decode.
  typedef enum logic [3:0] {
    PH_AZ  = 4'b0001,
    PH_INT = 4'b0010,
    PH_DE  = 4'b0100,
    PH_ZI  = 4'b1000
  } phase_e;

  // Decimal to packed BCD, ten digits, least significant digit at bit 0.
  function automatic logic [39:0] to_bcd(input int unsigned value);
    logic [39:0] res;
    int unsigned rest;
    res  = '0;
    rest = value;
    for (int i = 0; i < 10; i++) begin
      res[4*i +: 4] = 4'(rest % 10);
      rest          = rest / 10;
    end
    return res;
  endfunction

endpackage

// File: rtl/dsc_rst_sync.sv
module dsc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/dsc_bcd_counter.sv
module dsc_bcd_counter #(
  parameter int unsigned DIGITS = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  inc_i,
  output logic [4*DIGITS-1:0]   value_o
);

  logic [3:0]        dig_q [DIGITS];
  logic [3:0]        dig_d [DIGITS];
  logic [DIGITS-1:0] carry;

  assign carry[0] = inc_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    assign dig_d[g] = clr_i    ? 4'd0 :
                      carry[g] ? ((dig_q[g] == 4'd9) ? 4'd0 : dig_q[g] + 4'd1) :
                                 dig_q[g];
    if (g < DIGITS - 1) begin : g_carry
      assign carry[g+1] = carry[g] && (dig_q[g] == 4'd9);
    end
    assign value_o[4*g +: 4] = dig_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DIGITS; i++) dig_q[i] <= 4'd0;
    end else if (clr_i || inc_i) begin
      for (int i = 0; i < DIGITS; i++) dig_q[i] <= dig_d[i];
    end
  end

endmodule

// File: rtl/dsc_result_reg.sv
module dsc_result_reg #(
  parameter int unsigned BW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [BW-1:0] cnt_i,
  input  logic          over_in_i,
  input  logic          under_in_i,
  input  logic          clr_over_i,
  input  logic          clr_under_i,
  output logic [BW-1:0] reading_o,
  output logic          over_o,
  output logic          under_o
);

  logic [BW-1:0] reading_q, reading_d;
  logic          over_q, over_d, under_q, under_d;
  logic          flag_en;

  always_comb begin
    reading_d = load_i ? cnt_i : reading_q;
    over_d    = over_q;
    under_d   = under_q;
    if (load_i) begin
      over_d  = over_in_i;
      under_d = under_in_i;
    end else begin
      if (clr_over_i)  over_d  = 1'b0;
      if (clr_under_i) under_d = 1'b0;
    end
    flag_en = load_i || clr_over_i || clr_under_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reading_q <= '0;
    end else if (load_i) begin
      reading_q <= reading_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      over_q  <= 1'b0;
      under_q <= 1'b0;
    end else if (flag_en) begin
      over_q  <= over_d;
      under_q <= under_d;
    end
  end

  assign reading_o = reading_q;
  assign over_o    = over_q;
  assign under_o   = under_q;

endmodule

// File: rtl/dsc_sequencer.sv
module dsc_sequencer
  import dsc_pkg::*;
#(
  parameter int unsigned INT_COUNTS  = 10000,
  parameter int unsigned FULL_SCALE  = 20000,
  parameter int unsigned CYCLE_CLKS  = 40002,
  parameter int unsigned ZI_NORM     = 200,
  parameter int unsigned ZI_OVER     = 6200,
  parameter int unsigned UNDER_LIMIT = 1800,
  parameter int unsigned DIGITS      = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                comp_i,
  input  logic                run_i,
  output logic [3:0]          phase_sel_o,
  output logic                busy_o,
  output logic                pol_o,
  output logic                over_o,
  output logic                under_o,
  output logic [4*DIGITS-1:0] reading_o
);

  localparam int unsigned BW       = 4 * DIGITS;
  localparam int unsigned INT_CLKS = INT_COUNTS + 1;
  localparam int unsigned TICK_W   = $clog2(CYCLE_CLKS);
  localparam int unsigned ZI_MAX   = (ZI_OVER > ZI_NORM) ? ZI_OVER : ZI_NORM;
  localparam int unsigned ZW       = $clog2(ZI_MAX);

  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(CYCLE_CLKS - 1);
  localparam logic [TICK_W-1:0] INT_LAST  = TICK_W'(INT_CLKS - 1);
  localparam logic [ZW-1:0]     ZN_LOAD   = ZW'(ZI_NORM - 1);
  localparam logic [ZW-1:0]     ZO_LOAD   = ZW'(ZI_OVER - 1);
  localparam logic [BW-1:0]     FS_BCD    = BW'(to_bcd(FULL_SCALE));
  localparam logic [BW-1:0]     UL_BCD    = BW'(to_bcd(UNDER_LIMIT));

  logic              rst_core_n;
  phase_e            phase_q, phase_d;
  logic [TICK_W-1:0] tick_q, tick_d;
  logic [ZW-1:0]     zcnt_q, zcnt_d;
  logic              zc_q, zc_d;
  logic              first_q, first_d;
  logic              pol_q, pol_d;
  logic              load_q, load_d;
  logic              ovr_q, ovr_d;
  logic              cnt_clr, cnt_inc;
  logic              clr_over, clr_under;
  logic [BW-1:0]     cnt_bcd;
  logic              cnt_at_fs;
  logic              under_in;

  dsc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_core_n)
  );

  assign cnt_at_fs = (cnt_bcd == FS_BCD);
  assign under_in  = (cnt_bcd <= UL_BCD);

  // Next-state logic
  always_comb begin
    phase_d   = phase_q;
    tick_d    = tick_q;
    zcnt_d    = zcnt_q;
    zc_d      = zc_q;
    first_d   = 1'b0;
    pol_d     = pol_q;
    load_d    = 1'b0;
    ovr_d     = ovr_q;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    clr_over  = 1'b0;
    clr_under = 1'b0;
    case (phase_q)
      PH_AZ: begin
        if (tick_q == TICK_LAST) begin
          if (run_i) begin
            phase_d   = PH_INT;
            tick_d    = '0;
            clr_under = 1'b1;
          end
        end else begin
          tick_d = tick_q + 1'b1;
        end
      end
      PH_INT: begin
        tick_d = tick_q + 1'b1;
        if (tick_q == INT_LAST) begin
          phase_d  = PH_DE;
          pol_d    = comp_i;
          cnt_clr  = 1'b1;
          clr_over = 1'b1;
          first_d  = 1'b1;
          zc_d     = 1'b0;
        end
      end
      PH_DE: begin
        tick_d = tick_q + 1'b1;
        zc_d   = comp_i ^ pol_q;
        if (!first_q) begin
          if (zc_q) begin
            phase_d = PH_ZI;
            ovr_d   = 1'b0;
            load_d  = 1'b1;
            zcnt_d  = ZN_LOAD;
          end else begin
            cnt_inc = 1'b1;
            if (cnt_at_fs) begin
              phase_d = PH_ZI;
              ovr_d   = 1'b1;
              load_d  = 1'b1;
              zcnt_d  = ZO_LOAD;
            end
          end
        end
      end
      PH_ZI: begin
        tick_d = tick_q + 1'b1;
        if (zcnt_q == '0) begin
          phase_d = PH_AZ;
        end else begin
          zcnt_d = zcnt_q - 1'b1;
        end
      end
      default: phase_d = PH_AZ;
    endcase
  end

  // State registers
  always_ff @(posedge clk_i or negedge rst_core_n) begin
    if (!rst_core_n) begin
      phase_q <= PH_AZ;
      tick_q  <= '0;
      zcnt_q  <= '0;
      zc_q    <= 1'b0;
      first_q <= 1'b0;
      pol_q   <= 1'b0;
      load_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      tick_q  <= tick_d;
      zcnt_q  <= zcnt_d;
      zc_q    <= zc_d;
      first_q <= first_d;
      pol_q   <= pol_d;
      load_q  <= load_d;
      ovr_q   <= ovr_d;
    end
  end

  dsc_bcd_counter #(.DIGITS(DIGITS)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_core_n),
    .clr_i   (cnt_clr),
    .inc_i   (cnt_inc),
    .value_o (cnt_bcd)
  );

  dsc_result_reg #(.BW(BW)) u_result (
    .clk_i       (clk_i),
    .rst_ni      (rst_core_n),
    .load_i      (load_q),
    .cnt_i       (cnt_bcd),
    .over_in_i   (ovr_q),
    .under_in_i  (under_in),
    .clr_over_i  (clr_over),
    .clr_under_i (clr_under),
    .reading_o   (reading_o),
    .over_o      (over_o),
    .under_o     (under_o)
  );

  assign phase_sel_o = phase_q;
  assign busy_o      = (phase_q == PH_INT) || (phase_q == PH_DE);
  assign pol_o       = pol_q;

endmodule

// File: rtl/dsc_sequencer_chk.sv
module dsc_sequencer_chk #(
  parameter int unsigned INT_COUNTS = 10000,
  parameter int unsigned DIGITS     = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [3:0]          sel_i,
  input logic                busy_i,
  input logic                pol_i,
  input logic                over_i,
  input logic                under_i,
  input logic [4*DIGITS-1:0] reading_i
);

  localparam int unsigned INT_CLKS = INT_COUNTS + 1;

  int unsigned int_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_len <= 0;
    end else if (sel_i[1]) begin
      int_len <= int_len + 1;
    end else begin
      int_len <= 0;
    end
  end

  assert_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sel_i) == 1);

  assert_order_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i != $past(sel_i)) |-> (sel_i == {$past(sel_i[2:0]), $past(sel_i[3])}));

  assert_int_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sel_i[1]) |-> (int_len == INT_CLKS));

  assert_pol_update_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_i != $past(pol_i)) |-> $rose(sel_i[2]));

  assert_busy_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> sel_i[1]);

  assert_busy_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> sel_i[3]);

  assert_over_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_i[2]) |-> !over_i);

  assert_under_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_i[1]) |-> !under_i);

  assert_flags_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(over_i && under_i));

  assert_reading_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reading_i != $past(reading_i)) |-> ($past(sel_i[3]) && !$past(sel_i[3], 2)));

endmodule

bind dsc_sequencer dsc_sequencer_chk #(
  .INT_COUNTS (INT_COUNTS),
  .DIGITS     (DIGITS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_i     (phase_sel_o),
  .busy_i    (busy_o),
  .pol_i     (pol_o),
  .over_i    (over_o),
  .under_i   (under_o),
  .reading_i (reading_o)
);

// File: tb/tb_dsc_sequencer.sv
module tb_dsc_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int P_INT = 100;
  localparam int P_FS  = 200;
  localparam int P_CYC = 402;
  localparam int P_ZN  = 20;
  localparam int P_ZO  = 62;
  localparam int P_UL  = 18;
  localparam int P_DIG = 5;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        comp_i = 1'b1;
  logic        run_i = 1'b1;
  logic [3:0]  sel_o;
  logic        busy_o, pol_o, over_o, under_o;
  logic [19:0] reading_o;

  dsc_sequencer #(
    .INT_COUNTS(P_INT), .FULL_SCALE(P_FS), .CYCLE_CLKS(P_CYC),
    .ZI_NORM(P_ZN), .ZI_OVER(P_ZO), .UNDER_LIMIT(P_UL), .DIGITS(P_DIG)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .comp_i(comp_i), .run_i(run_i),
    .phase_sel_o(sel_o), .busy_o(busy_o), .pol_o(pol_o),
    .over_o(over_o), .under_o(under_o), .reading_o(reading_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [19:0] bcd(input int v);
    logic [19:0] r;
    int t;
    t = v;
    for (int i = 0; i < 5; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  // Behavioural reference model: phase 0 AZ, 1 INT, 2 DE, 3 ZI
  int m_ph = 0, m_tick = 0, m_sync = 0, m_k = 0, m_zleft = 0, m_res = 0, m_rd = 0;
  bit m_pol = 0, m_over = 0, m_under = 0, m_zfirst = 0;
  int cur_v = 50;
  bit cur_s = 1;
  int conv_cnt = 0;
  int qv[$];
  bit qs[$];
  int cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_ni) begin
      m_ph = 0; m_tick = 0; m_sync = 0; m_pol = 0; m_over = 0; m_under = 0;
      m_rd = 0; m_k = 0; m_zleft = 0; m_zfirst = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      case (m_ph)
        0: begin
          if (m_tick == P_CYC - 1) begin
            if (run_i) begin
              m_ph = 1; m_tick = 0; m_under = 0;
              if (qv.size() > 0) begin
                cur_v = qv.pop_front();
                cur_s = qs.pop_front();
              end else begin
                cur_v = 50; cur_s = 1;
              end
            end
          end else m_tick++;
        end
        1: begin
          if (m_tick == P_INT) begin
            m_ph = 2; m_pol = cur_s; m_over = 0; m_k = 0;
          end
          m_tick++;
        end
        2: begin
          m_tick++;
          if ((cur_v <= P_FS && m_k == cur_v + 1) || (cur_v > P_FS && m_k == P_FS + 1)) begin
            m_ph = 3;
            m_res = (cur_v <= P_FS) ? cur_v : P_FS + 1;
            m_zleft = (cur_v > P_FS) ? P_ZO : P_ZN;
            m_zfirst = 1;
            conv_cnt++;
          end
          m_k++;
        end
        default: begin
          m_tick++;
          if (m_zfirst) begin
            m_rd = m_res; m_over = (m_res > P_FS); m_under = (m_res <= P_UL); m_zfirst = 0;
          end
          m_zleft--;
          if (m_zleft == 0) m_ph = 0;
        end
      endcase
    end
  end

  // Analog model: integrator sign follows the input, crossing at DE index cur_v
  always @(negedge clk) begin
    comp_i <= cur_s ^ ((m_ph == 2) && (m_k >= cur_v));
  end

  // Per-clock comparison against the model, plus timing monitors
  logic [3:0] prev_sel = 4'b0001;
  int int_len = 0, zi_len = 0, last_rise = -1, int_rises = 0;
  bit free_mon = 1;

  always @(negedge clk) begin
    chk(sel_o == 4'(1 << m_ph), "R1 phase select", int'(sel_o), 1 << m_ph);
    chk(busy_o == (m_ph == 1 || m_ph == 2), "R6 busy", int'(busy_o), int'(m_ph == 1 || m_ph == 2));
    chk(pol_o == m_pol, "R5 polarity", int'(pol_o), int'(m_pol));
    chk(over_o == m_over, "R7 overrange", int'(over_o), int'(m_over));
    chk(under_o == m_under, "R8 underrange", int'(under_o), int'(m_under));
    chk(reading_o == bcd(m_rd), "R4 R10 reading", int'(reading_o), int'(bcd(m_rd)));

    if (sel_o[1] && !prev_sel[1]) begin
      int_rises++;
      if (free_mon) begin
        if (last_rise >= 0) chk(cyc - last_rise == P_CYC, "R2 spacing", cyc - last_rise, P_CYC);
        last_rise = cyc;
      end
    end
    if (sel_o[1]) int_len++;
    else if (prev_sel[1]) begin
      chk(int_len == P_INT + 1, "R3 integrate length", int_len, P_INT + 1);
      int_len = 0;
    end
    if (sel_o[3]) zi_len++;
    else if (prev_sel[3]) begin
      chk(zi_len == (m_over ? P_ZO : P_ZN), "R9 zero-integrator length", zi_len, m_over ? P_ZO : P_ZN);
      zi_len = 0;
    end
    prev_sel = sel_o;
  end

  initial begin
    int held_rises;
    // V values cover: zero both signs, one, underrange limit and one above,
    // full scale, one past full scale, deep overrange, and mid values.
    qv = '{0, 0, 1, 18, 19, 200, 201, 250, 123, 7, 60, 100, 5};
    qs = '{1, 0, 1, 1, 0, 1, 1, 0, 0, 1, 1, 0, 1};
    run_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(sel_o == 4'b0001, "R13 reset phase", int'(sel_o), 1);
    chk({busy_o, pol_o, over_o, under_o} == 4'b0, "R13 reset flags",
        int'({busy_o, pol_o, over_o, under_o}), 0);
    chk(reading_o == 20'h0, "R13 reset reading", int'(reading_o), 0);
    rst_ni = 1'b1;

    wait (conv_cnt == 10);
    @(negedge clk);
    run_i = 1'b0;
    free_mon = 0;
    last_rise = -1;
    repeat (5) @(negedge clk);
    run_i = 1'b1;                 // early pulse, still in zero-integrator
    @(negedge clk);
    run_i = 1'b0;
    held_rises = int_rises;
    repeat (3 * P_CYC) @(negedge clk);
    chk(int_rises == held_rises, "R12 early pulse ignored", int_rises, held_rises);
    chk(sel_o == 4'b0001, "R11 held in auto-zero", int'(sel_o), 1);
    chk(reading_o == bcd(7), "R11 reading held", int'(reading_o), int'(bcd(7)));
    run_i = 1'b1;
    @(negedge clk);
    chk(sel_o == 4'b0010, "R11 trigger starts integrate", int'(sel_o), 2);
    run_i = 1'b0;
    wait (conv_cnt == 11);
    repeat (2 * P_CYC) @(negedge clk);
    chk(sel_o == 4'b0001, "R11 second hold", int'(sel_o), 1);
    run_i = 1'b1;
    wait (conv_cnt == 13);
    repeat (P_CYC) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule